// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is an I2C target that gives a host access to a small bank of 8-bit configuration registers. It samples SCL and SDA with a fast system clock and pulls SDA low through an active-high enable (`sda_oe_o`). The line itself is open-drain with an external pull-up. The register contents are brought out in parallel on `regs_o`, so neighbouring logic can use them directly. Register 0x00 is a fixed identification value. All other registers reset to zero.

The target has two access modes, chosen by `standby_i`. In normal mode, an internal pointer is loaded by the first byte after a write address. It then advances after every data byte, whether the byte is written or read. In standby mode, only the three registers 0x01 to 0x03 can be reached, and a transaction touches exactly one register. The pointer does not move in standby mode. Any attempt to leave that window is refused with a NACK.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The address byte 0xD0 (7-bit address 0x68, direction bit 0) opens a write, and 0xD1 opens a read; both are ACKed. Any other address byte is NACKed, and SDA then stays released for the remaining bytes until the next START.
- R2: In normal mode, the first byte after 0xD0 loads the pointer. Each later byte is written to the register at the pointer, and the pointer then advances by one. Every one of these bytes is ACKed.
- R3: A normal-mode read returns bytes MSB first, starting at the pointer left by an earlier data-less write. The pointer advances by one after each byte that is sent.
- R4: When the master does not ACK a read byte, the read ends. The target keeps SDA released until the next START, so any further bytes clocked out read as 0xFF.
- R5: Register 0x00 always reads 0xA1. A byte written to it is ACKed and leaves it unchanged.
- R6: In standby mode, a pointer byte outside 0x01..0x03 is NACKed. The pointer and the register bank are left unchanged.
- R7: In standby mode, only one data byte is accepted per transaction, and the pointer does not advance. A second data byte is NACKed and not stored. A read sends one byte and then releases SDA, even if the master ACKs.
- R8: `sda_oe_o` changes only while SCL is low.
- R9: A repeated START part-way through a byte discards that byte. Reception restarts with an address byte.
- R10: After reset, SDA is released, register 0x00 holds 0xA1 and every other register holds 0x00.
- R11: A STOP condition releases SDA and ends the transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 40x SCL in normal mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| standby_i | input | 1 | 1 selects the restricted standby access mode |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NREGS*8 | Register bank; register i sits at bits 8*i+7 down to 8*i |

## Verification
The bench runs several normal-mode patterns:
- A burst write of three bytes shows that the pointer auto-increments.
- A write to the identification register shows that the ID register ignores the write while still ACKing it.
- A pointer-set followed by a two-byte read shows read ordering, and the master NACK then shows SDA release.

A foreign address byte tells address filtering apart from general ACK behaviour. A START injected in the middle of a byte shows that reception resynchronises. With `standby_i` high, the same traffic is repeated against the register window and against the one-register limit. This separates standby restrictions from normal-mode auto-increment.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } eng_st_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } rx_kind_t;

  localparam logic [7:0] SB_FIRST = 8'h01;
  localparam logic [7:0] SB_LAST  = 8'h03;

  // register index reachable while in standby
  function automatic logic win_ok(input logic [7:0] a);
    return (a >= SB_FIRST) && (a <= SB_LAST);
  endfunction

  // pointer after one data byte: frozen in standby
  function automatic logic [7:0] ptr_step(input logic [7:0] p, input logic sb);
    return sb ? p : p + 8'd1;
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_m, sda_m, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; sda_m <= 1'b1;
      scl_s <= 1'b1; sda_s <= 1'b1;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= scl_i; sda_m <= sda_i;
      scl_s <= scl_m; sda_s <= sda_m;
      scl_q <= scl_s; sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int         NREGS    = 11,
  parameter logic [7:0] ID_VALUE = 8'hA1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [7:0]         waddr,
  input  logic [7:0]         wdata,
  input  logic [7:0]         raddr,
  output logic [7:0]         rdata,
  output logic [NREGS*8-1:0] regs_flat
);
  logic [7:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == 0) begin : g_id
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[i] <= ID_VALUE;
        else        regs[i] <= regs[i];
      end
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     regs[i] <= 8'h00;
        else if (we && waddr == 8'(i))  regs[i] <= wdata;
      end
    end
    assign regs_flat[i*8 +: 8] = regs[i];
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NREGS; i++)
      if (raddr == 8'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rdata,
  output logic [7:0] ptr,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_end_ev
);
  eng_st_t    state;
  rx_kind_t   kind;
  logic [2:0] cnt;
  logic       full, ack_q, rd_mode, done_one, mack;
  logic [7:0] shreg, txsh;
  logic       dec_ack, dec_rd, dec_wr, byte_end;

  // decision for the byte just received
  always_comb begin
    dec_ack = 1'b0;
    dec_rd  = 1'b0;
    dec_wr  = 1'b0;
    unique case (kind)
      K_ADDR: if (addr_hit(shreg, DEV_ADDR)) begin
        if (!shreg[0]) dec_ack = 1'b1;
        else begin
          dec_rd  = 1'b1;
          dec_ack = !standby || win_ok(ptr);
        end
      end
      K_PTR:  dec_ack = !standby || win_ok(shreg);
      K_DATA: begin
        dec_ack = !(standby && done_one);
        dec_wr  = dec_ack;
      end
      default: dec_ack = 1'b0;
    endcase
  end

  assign byte_end  = (state == ST_RX) && scl_fall && full;
  assign wr_en     = byte_end && dec_wr;
  assign wr_addr   = ptr;
  assign wr_data   = shreg;
  assign rd_end_ev = (state == ST_TX_ACK) && scl_fall && !(mack && !standby);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; kind <= K_ADDR; cnt <= '0; full <= 1'b0;
      ack_q <= 1'b0; rd_mode <= 1'b0; done_one <= 1'b0; mack <= 1'b0;
      shreg <= '0; txsh <= '0; ptr <= '0; sda_oe <= 1'b0;
    end else if (start_ev) begin
      state <= ST_RX; kind <= K_ADDR; cnt <= '0; full <= 1'b0;
      done_one <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE; sda_oe <= 1'b0; full <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) full <= 1'b1;
          end else if (byte_end) begin
            state   <= ST_RX_ACK;
            sda_oe  <= dec_ack;
            ack_q   <= dec_ack;
            rd_mode <= dec_rd;
            if (kind == K_PTR && dec_ack) ptr <= shreg;
            if (dec_wr) begin
              ptr      <= ptr_step(ptr, standby);
              done_one <= 1'b1;
            end
            kind <= (kind == K_ADDR) ? K_PTR : K_DATA;
          end
        end
        ST_RX_ACK: if (scl_fall) begin
          full <= 1'b0;
          cnt  <= '0;
          if (!ack_q) begin
            state <= ST_IDLE; sda_oe <= 1'b0;
          end else if (rd_mode) begin
            txsh   <= rdata;
            sda_oe <= ~rdata[7];
            ptr    <= ptr_step(ptr, standby);
            state  <= ST_TX;
          end else begin
            sda_oe <= 1'b0; state <= ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt == 3'd7) begin
            sda_oe <= 1'b0; state <= ST_TX_ACK;
          end else begin
            txsh   <= {txsh[6:0], 1'b0};
            sda_oe <= ~txsh[6];
            cnt    <= cnt + 3'd1;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack && !standby) begin
              txsh   <= rdata;
              sda_oe <= ~rdata[7];
              ptr    <= ptr_step(ptr, standby);
              cnt    <= '0;
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0; state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter int         NREGS    = 11,
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter logic [7:0] ID_VALUE = 8'hA1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               standby_i,
  output logic               sda_oe_o,
  output logic [NREGS*8-1:0] regs_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       wr_en, rd_end_ev;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  i2c_line_sync sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR)) eng_i (
    .clk(clk), .rst_n(rst_n), .standby(standby_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .rdata(rd_data), .ptr(rd_addr), .sda_oe(sda_oe_o),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_end_ev(rd_end_ev)
  );

  i2c_reg_bank #(.NREGS(NREGS), .ID_VALUE(ID_VALUE)) bank_i (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data), .regs_flat(regs_o)
  );
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk #(
  parameter int         NREGS    = 11,
  parameter logic [7:0] ID_VALUE = 8'hA1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               standby_i,
  input logic               sda_oe_o,
  input logic               scl_s,
  input logic               start_ev,
  input logic               stop_ev,
  input logic               wr_en,
  input logic [7:0]         wr_addr,
  input logic               rd_end_ev,
  input logic [NREGS*8-1:0] regs_o
);
  logic [1:0] wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        wr_seen <= '0;
    else if (start_ev)                 wr_seen <= '0;
    else if (wr_en && wr_seen != 2'd3) wr_seen <= wr_seen + 2'd1;
  end

  a_r5_id_constant: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[7:0] == ID_VALUE);

  a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && standby_i) |-> (wr_addr >= 8'h01 && wr_addr <= 8'h03));

  a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && standby_i) |-> (wr_seen == 2'd0));

  a_r2_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe_o);

  a_r8_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);

  a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe_o);

  a_r4_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end_ev |=> !sda_oe_o);
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NREGS(NREGS), .ID_VALUE(ID_VALUE)) chk_i (
  .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .sda_oe_o(sda_oe_o),
  .scl_s(scl_s), .start_ev(start_ev), .stop_ev(stop_ev), .wr_en(wr_en),
  .wr_addr(wr_addr), .rd_end_ev(rd_end_ev), .regs_o(regs_o)
);

// File: tb/i2c_cfg_slave_tb_top.sv
module i2c_cfg_slave_tb_top;
  localparam int NREGS = 11;
  localparam int Q     = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic standby = 1'b0;
  logic sda_oe;
  logic [NREGS*8-1:0] regs;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  int r8_viol = 0;
  bit done = 1'b0;

  typedef struct { string tag; int val; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  i2c_cfg_slave #(.NREGS(NREGS)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .standby_i(standby), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  // R8 monitor: SDA enable must not move while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl) r8_viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] reg_at(input int i);
    return regs[8*i +: 8];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input string tag, input int v);
    exp_t e;
    e.tag = tag; e.val = v;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int act);
    exp_t e;
    e = exp_q.pop_front();
    check(e.tag, act, e.val);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output int ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq();
    ack = (sda_line == 1'b0) ? 1 : 0;
    wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit mack, output int v);
    logic [7:0] b;
    b = '0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(); scl = 1'b1; wq();
      b[i] = sda_line;
      wq(); scl = 1'b0; wq();
    end
    sda_m = mack ? 1'b0 : 1'b1; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    sda_m = 1'b1;
    v = int'(b);
  endtask

  // driver: expected ACK pushed before the byte, popped by observe
  task automatic tx(input logic [7:0] b, input int ack_exp, input string tag);
    int a;
    push_exp(tag, ack_exp);
    send_byte(b, a);
    observe(a);
  endtask

  task automatic rx(input bit mack, input int exp, input string tag);
    int v;
    push_exp(tag, exp);
    recv_byte(mack, v);
    observe(v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 sda released", int'(sda_oe), 0);
    check("R10 id reg", int'(reg_at(0)), 8'hA1);
    for (int i = 1; i < NREGS; i++) check("R10 reg zero", int'(reg_at(i)), 0);

    // R2 burst write with auto-increment
    i2c_start();
    tx(8'hD0, 1, "R1 write addr ack");
    tx(8'h01, 1, "R2 ptr ack");
    tx(8'hAA, 1, "R2 data ack");
    tx(8'hBB, 1, "R2 data ack");
    tx(8'hCC, 1, "R2 data ack");
    i2c_stop();
    check("R11 released after stop", int'(sda_oe), 0);
    check("R2 reg1", int'(reg_at(1)), 8'hAA);
    check("R2 reg2", int'(reg_at(2)), 8'hBB);
    check("R2 reg3", int'(reg_at(3)), 8'hCC);

    // R5 identification register is read-only
    i2c_start();
    tx(8'hD0, 1, "R5 addr ack");
    tx(8'h00, 1, "R5 ptr ack");
    tx(8'h55, 1, "R5 write acked");
    i2c_stop();
    check("R5 id unchanged", int'(reg_at(0)), 8'hA1);
    i2c_start(); tx(8'hD0, 1, "R5 addr"); tx(8'h00, 1, "R5 ptr"); i2c_stop();
    i2c_start(); tx(8'hD1, 1, "R1 read addr ack");
    rx(1'b0, 8'hA1, "R5 id readback");
    i2c_stop();

    // R3 read from pointer, R4 NACK releases
    i2c_start(); tx(8'hD0, 1, "R3 addr"); tx(8'h02, 1, "R3 ptr"); i2c_stop();
    i2c_start(); tx(8'hD1, 1, "R3 read addr");
    rx(1'b1, 8'hBB, "R3 first byte");
    rx(1'b0, 8'hCC, "R3 second byte");
    rx(1'b0, 8'hFF, "R4 released after nack");
    i2c_stop();

    // R1 foreign address
    i2c_start();
    tx(8'hA0, 0, "R1 foreign addr nack");
    tx(8'h77, 0, "R1 released after foreign addr");
    i2c_stop();
    check("R1 reg1 untouched", int'(reg_at(1)), 8'hAA);

    // R9 repeated start mid-byte
    i2c_start();
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    i2c_start();
    tx(8'hD0, 1, "R9 addr after restart");
    tx(8'h04, 1, "R9 ptr");
    tx(8'h5A, 1, "R9 data");
    i2c_stop();
    check("R9 reg4", int'(reg_at(4)), 8'h5A);

    // standby mode
    standby = 1'b1;
    wq();
    i2c_start();
    tx(8'hD0, 1, "R6 standby addr");
    tx(8'h05, 0, "R6 out-of-window ptr nack");
    tx(8'h11, 0, "R6 released after nack");
    i2c_stop();
    check("R6 reg5 unchanged", int'(reg_at(5)), 0);

    i2c_start();
    tx(8'hD0, 1, "R7 addr");
    tx(8'h02, 1, "R7 ptr in window");
    tx(8'h66, 1, "R7 first data ack");
    tx(8'h77, 0, "R7 second data nack");
    i2c_stop();
    check("R7 reg2 written", int'(reg_at(2)), 8'h66);
    check("R7 reg3 not incremented into", int'(reg_at(3)), 8'hCC);

    i2c_start(); tx(8'hD0, 1, "R7 addr"); tx(8'h03, 1, "R7 ptr"); i2c_stop();
    i2c_start(); tx(8'hD1, 1, "R7 read addr");
    rx(1'b1, 8'hCC, "R7 single read byte");
    rx(1'b0, 8'hFF, "R7 no second byte");
    i2c_stop();
    standby = 1'b0;

    check("R8 no SDA change with SCL high", r8_viol, 0);
    check("R11 final release", int'(sda_oe), 0);
    finish_run();
  end
endmodule